// File: doc/BRIEF.md
# Bit-Band Alias Bridge

This bridge sits on the path from a bus master to a memory or peripheral slave. It gives software single-bit access to a byte-addressed region. A large alias window is laid over a smaller bit region, and every 32-bit word of the window stands for one bit of the region. Any access that misses the window reaches the slave unchanged.

A read in the window is turned into a one-byte read of the target byte. The selected bit comes back in bit 0 of the read data, and all other bits are zero. A write in the window looks only at bit 0 of the write data. The bridge sets or clears the selected bit by reading the byte and writing it back. It holds a lock toward the slave arbiter for both halves of that sequence, and it keeps the master waiting until the write has been accepted.

The slave port answers in the cycle in which it is ready, so any access that is not an alias write completes in one handshake, in the same cycle it is presented.

Top module: `bb_bridge`

## Requirements
- R1: A request whose address is outside the alias window reaches the slave in the same cycle with the same address, direction, write data and byte enables. The slave's ready and full read word come straight back to the master.
- R2: A request to the bit region's own addresses is an ordinary word or byte access. Partial byte enables change only the enabled bytes.
- R3: The alias address ALIAS_BASE + 32·k + 4·b (k = byte offset, b = 0..7) selects bit b of the region byte at REGION_BASE + k. The bytes sit on the data bus little-endian, so byte address[1:0] picks lane bits [8·lane+7 : 8·lane].
- R4: An alias read completes in the cycle it is presented. It returns the selected bit in bit 0, with bits [DATA_W-1:1] zero.
- R5: An alias write sets the selected bit when write-data bit 0 is 1 and clears it when bit 0 is 0. All upper write-data bits are ignored.
- R6: An alias write leaves the other seven bits of the target byte unchanged, and every other byte as well.
- R7: An alias write issues exactly one locked one-byte read followed by one locked one-byte write. Each uses a single byte enable, and the lock stays high from the start of the read until the write is accepted.
- R8: The master's ready stays low for as long as the lock is high. With a slave that is always ready, the alias write is acknowledged exactly three cycles after it is first presented: the cycle after the write half is accepted.
- R9: After reset the bridge is idle. The lock is low, and no slave request is made while the master is idle.
- R10: When the slave stalls, each half of the read-modify-write waits for the slave's ready, with no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| m_valid | input | 1 | Master request valid |
| m_write | input | 1 | Master request is a write |
| m_addr | input | ADDR_W | Master byte address |
| m_wdata | input | DATA_W | Master write data |
| m_be | input | DATA_W/8 | Master byte enables |
| m_ready | output | 1 | Request accepted (read data valid for reads) |
| m_rdata | output | DATA_W | Read data to master |
| s_valid | output | 1 | Slave request valid |
| s_write | output | 1 | Slave request is a write |
| s_lock | output | 1 | Hold arbitration during read-modify-write |
| s_addr | output | ADDR_W | Slave byte address |
| s_wdata | output | DATA_W | Slave write data |
| s_be | output | DATA_W/8 | Slave byte enables |
| s_ready | input | 1 | Slave accepts the request this cycle |
| s_rdata | input | DATA_W | Slave read data, valid with s_ready |

## Verification
A sequencer stuck or skipping a phase shows up at once on the lock and ready pins. Either the acknowledge cycle count leaves three, or a locked write appears with no locked read before it. A wrong captured byte or bit index does not appear at the handshake. It appears on the next direct read of the region word, where a neighbouring bit or byte differs from the model. So every alias write in the sweep is followed at once by an alias read-back and a full-word direct read. A decode error at a window edge shows as an RMW delay, or as an unexpected change to the region, on the first address past the window.

// File: rtl/bb_pkg.sv
package bb_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_FETCH  = 2'd1,
        PH_STORE  = 2'd2,
        PH_FINISH = 2'd3
    } bb_phase_e;

endpackage

// File: rtl/bb_decode.sv
module bb_decode #(
    parameter int                ADDR_W      = 32,
    parameter int                REGION_AW   = 20,
    parameter logic [ADDR_W-1:0] REGION_BASE = 32'h4000_0000,
    parameter logic [ADDR_W-1:0] ALIAS_BASE  = 32'h4200_0000
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [ADDR_W-1:0] tgt_addr,
    output logic [2:0]        bit_sel
);
    localparam int ALIAS_AW = REGION_AW + 5;

    logic [ADDR_W-1:0] offset;

    always_comb begin
        offset   = addr - ALIAS_BASE;
        hit      = (addr >= ALIAS_BASE) && ((offset >> ALIAS_AW) == '0);
        tgt_addr = REGION_BASE + (offset >> 5);
        bit_sel  = offset[4:2];
    end

endmodule

// File: rtl/bb_bitops.sv
module bb_bitops #(
    parameter int DATA_W = 32,
    localparam int BE_W   = DATA_W / 8,
    localparam int LANE_W = (BE_W > 1) ? $clog2(BE_W) : 1
) (
    input  logic [DATA_W-1:0] word,
    input  logic [LANE_W-1:0] lane,
    input  logic [2:0]        bit_sel,
    input  logic              new_val,
    output logic              bit_out,
    output logic [7:0]        merged
);
    logic [7:0] lane_byte;

    always_comb begin
        lane_byte        = word[lane*8 +: 8];
        bit_out          = lane_byte[bit_sel];
        merged           = lane_byte;
        merged[bit_sel]  = new_val;
    end

endmodule

// File: rtl/bb_seq.sv
module bb_seq
    import bb_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [2:0]        req_bit,
    input  logic              req_val,
    input  logic              s_ready,
    input  logic [7:0]        merged,
    output bb_phase_e         phase,
    output logic [ADDR_W-1:0] cap_addr,
    output logic [2:0]        cap_bit,
    output logic              cap_val,
    output logic [7:0]        wr_byte
);
    typedef struct packed {
        bb_phase_e         ph;
        logic [ADDR_W-1:0] addr;
        logic [2:0]        bsel;
        logic              val;
        logic [7:0]        data;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    always_comb begin
        ctx_d = ctx_q;
        unique case (ctx_q.ph)
            PH_IDLE: begin
                if (start) begin
                    ctx_d.ph   = PH_FETCH;
                    ctx_d.addr = req_addr;
                    ctx_d.bsel = req_bit;
                    ctx_d.val  = req_val;
                end
            end
            PH_FETCH: begin
                if (s_ready) begin
                    ctx_d.data = merged;
                    ctx_d.ph   = PH_STORE;
                end
            end
            PH_STORE: begin
                if (s_ready) ctx_d.ph = PH_FINISH;
            end
            PH_FINISH: ctx_d.ph = PH_IDLE;
            default:   ctx_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q <= '{ph: PH_IDLE, addr: '0, bsel: '0, val: 1'b0, data: '0};
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign phase    = ctx_q.ph;
    assign cap_addr = ctx_q.addr;
    assign cap_bit  = ctx_q.bsel;
    assign cap_val  = ctx_q.val;
    assign wr_byte  = ctx_q.data;

endmodule

// File: rtl/bb_bridge.sv
module bb_bridge
    import bb_pkg::*;
#(
    parameter int                ADDR_W      = 32,
    parameter int                DATA_W      = 32,
    parameter int                REGION_AW   = 20,
    parameter logic [ADDR_W-1:0] REGION_BASE = 32'h4000_0000,
    parameter logic [ADDR_W-1:0] ALIAS_BASE  = 32'h4200_0000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                m_valid,
    input  logic                m_write,
    input  logic [ADDR_W-1:0]   m_addr,
    input  logic [DATA_W-1:0]   m_wdata,
    input  logic [DATA_W/8-1:0] m_be,
    output logic                m_ready,
    output logic [DATA_W-1:0]   m_rdata,
    output logic                s_valid,
    output logic                s_write,
    output logic                s_lock,
    output logic [ADDR_W-1:0]   s_addr,
    output logic [DATA_W-1:0]   s_wdata,
    output logic [DATA_W/8-1:0] s_be,
    input  logic                s_ready,
    input  logic [DATA_W-1:0]   s_rdata
);
    localparam int BE_W   = DATA_W / 8;
    localparam int LANE_W = (BE_W > 1) ? $clog2(BE_W) : 1;

    logic              alias_hit;
    logic [ADDR_W-1:0] tgt_addr;
    logic [2:0]        alias_bit;
    bb_phase_e         phase;
    logic [ADDR_W-1:0] cap_addr;
    logic [2:0]        cap_bit;
    logic              cap_val;
    logic [7:0]        wr_byte;
    logic              busy;
    logic [ADDR_W-1:0] sel_addr;
    logic [2:0]        sel_bit;
    logic              sel_val;
    logic [LANE_W-1:0] lane;
    logic [BE_W-1:0]   lane_be;
    logic              bit_out;
    logic [7:0]        merged;
    logic [DATA_W-1:0] wr_word;
    logic              start;

    bb_decode #(
        .ADDR_W(ADDR_W), .REGION_AW(REGION_AW),
        .REGION_BASE(REGION_BASE), .ALIAS_BASE(ALIAS_BASE)
    ) u_decode (
        .addr(m_addr), .hit(alias_hit), .tgt_addr(tgt_addr), .bit_sel(alias_bit)
    );

    assign busy     = (phase != PH_IDLE);
    assign sel_addr = busy ? cap_addr : tgt_addr;
    assign sel_bit  = busy ? cap_bit  : alias_bit;
    assign sel_val  = busy ? cap_val  : m_wdata[0];
    assign lane     = sel_addr[LANE_W-1:0];
    assign lane_be  = BE_W'(1) << lane;
    assign start    = m_valid && m_write && alias_hit;

    bb_bitops #(.DATA_W(DATA_W)) u_bitops (
        .word(s_rdata), .lane(lane), .bit_sel(sel_bit), .new_val(sel_val),
        .bit_out(bit_out), .merged(merged)
    );

    bb_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .req_addr(tgt_addr), .req_bit(alias_bit), .req_val(m_wdata[0]),
        .s_ready(s_ready), .merged(merged),
        .phase(phase), .cap_addr(cap_addr), .cap_bit(cap_bit),
        .cap_val(cap_val), .wr_byte(wr_byte)
    );

    for (genvar g = 0; g < BE_W; g++) begin : g_lane
        assign wr_word[g*8 +: 8] = wr_byte;
    end

    always_comb begin
        s_valid = 1'b0;
        s_write = 1'b0;
        s_addr  = m_addr;
        s_wdata = m_wdata;
        s_be    = m_be;
        m_ready = 1'b0;
        m_rdata = '0;
        unique case (phase)
            PH_IDLE: begin
                if (!alias_hit) begin
                    s_valid = m_valid;
                    s_write = m_write;
                    m_ready = s_ready;
                    m_rdata = s_rdata;
                end else if (!m_write) begin
                    s_valid = m_valid;
                    s_addr  = tgt_addr;
                    s_be    = lane_be;
                    m_ready = s_ready;
                    m_rdata = {{(DATA_W-1){1'b0}}, bit_out};
                end
            end
            PH_FETCH: begin
                s_valid = 1'b1;
                s_addr  = cap_addr;
                s_be    = lane_be;
            end
            PH_STORE: begin
                s_valid = 1'b1;
                s_write = 1'b1;
                s_addr  = cap_addr;
                s_wdata = wr_word;
                s_be    = lane_be;
            end
            PH_FINISH: m_ready = 1'b1;
            default: ;
        endcase
    end

    assign s_lock = (phase == PH_FETCH) || (phase == PH_STORE);

endmodule

// File: rtl/bb_bridge_chk.sv
module bb_bridge_chk #(
    parameter int                ADDR_W     = 32,
    parameter int                DATA_W     = 32,
    parameter int                REGION_AW  = 20,
    parameter logic [ADDR_W-1:0] ALIAS_BASE = 32'h4200_0000
) (
    input logic                clk,
    input logic                rst_n,
    input logic                m_valid,
    input logic                m_write,
    input logic [ADDR_W-1:0]   m_addr,
    input logic                m_ready,
    input logic [DATA_W-1:0]   m_rdata,
    input logic                s_valid,
    input logic                s_write,
    input logic                s_lock,
    input logic [ADDR_W-1:0]   s_addr,
    input logic [DATA_W/8-1:0] s_be,
    input logic                s_ready
);
    localparam int ALIAS_AW = REGION_AW + 5;

    logic in_window;
    assign in_window = (m_addr >= ALIAS_BASE) && (((m_addr - ALIAS_BASE) >> ALIAS_AW) == '0);

    assert_passthru_R1: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid && !in_window |-> s_valid && !s_lock && s_addr == m_addr && s_write == m_write);

    assert_read_bit0_R4: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid && !m_write && in_window && m_ready |-> m_rdata[DATA_W-1:1] == '0);

    assert_one_lane_R7: assert property (@(posedge clk) disable iff (!rst_n)
        s_lock |-> s_valid && $countones(s_be) == 1);

    assert_lock_starts_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_lock) |-> !s_write);

    assert_read_then_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        s_lock && !s_write && s_ready |=> s_lock && s_write);

    assert_hold_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        s_lock |-> !m_ready);

    assert_ack_after_store_R8: assert property (@(posedge clk) disable iff (!rst_n)
        s_lock && s_write && s_ready |=> !s_lock && m_ready);

    assert_stall_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        s_lock && !s_ready |=> s_lock && $stable(s_write) && $stable(s_addr));

endmodule

bind bb_bridge bb_bridge_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REGION_AW(REGION_AW), .ALIAS_BASE(ALIAS_BASE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .m_valid(m_valid), .m_write(m_write), .m_addr(m_addr),
    .m_ready(m_ready), .m_rdata(m_rdata), .s_valid(s_valid), .s_write(s_write),
    .s_lock(s_lock), .s_addr(s_addr), .s_be(s_be), .s_ready(s_ready)
);

// File: tb/bb_bridge_test.sv
module bb_bridge_test;
    localparam int          RAW    = 6;
    localparam int          NBYTE  = 1 << RAW;
    localparam logic [31:0] RBASE  = 32'h4000_0000;
    localparam logic [31:0] ABASE  = 32'h4200_0000;
    localparam logic [31:0] EBASE  = 32'h2000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_valid = 1'b0, m_write = 1'b0;
    logic [31:0] m_addr = '0, m_wdata = '0;
    logic [3:0]  m_be = '0;
    logic        m_ready;
    logic [31:0] m_rdata;
    logic        s_valid, s_write, s_lock;
    logic [31:0] s_addr, s_wdata;
    logic [3:0]  s_be;
    logic        s_ready = 1'b1;
    logic [31:0] s_rdata;

    logic [7:0]  rmem  [NBYTE];
    logic [7:0]  rref  [NBYTE];
    logic [31:0] emem  [16];
    logic [31:0] eref  [16];
    int          total = 0, fails = 0;
    logic        stall = 1'b0;
    int          rdy_cnt = 0;

    always #5 clk = ~clk;

    bb_bridge #(
        .ADDR_W(32), .DATA_W(32), .REGION_AW(RAW), .REGION_BASE(RBASE), .ALIAS_BASE(ABASE)
    ) uut (
        .clk(clk), .rst_n(rst_n), .m_valid(m_valid), .m_write(m_write), .m_addr(m_addr),
        .m_wdata(m_wdata), .m_be(m_be), .m_ready(m_ready), .m_rdata(m_rdata),
        .s_valid(s_valid), .s_write(s_write), .s_lock(s_lock), .s_addr(s_addr),
        .s_wdata(s_wdata), .s_be(s_be), .s_ready(s_ready), .s_rdata(s_rdata)
    );

    // slave model: combinational read, write on the accepting edge
    always_comb begin
        s_rdata = '0;
        if (s_addr[31:RAW] == RBASE[31:RAW]) begin
            for (int k = 0; k < 4; k++) s_rdata[k*8 +: 8] = rmem[{s_addr[RAW-1:2], 2'(k)}];
        end else if (s_addr[31:6] == EBASE[31:6]) begin
            s_rdata = emem[s_addr[5:2]];
        end
    end

    always @(posedge clk) begin
        if (s_valid && s_ready && s_write) begin
            for (int k = 0; k < 4; k++) begin
                if (s_be[k]) begin
                    if (s_addr[31:RAW] == RBASE[31:RAW]) rmem[{s_addr[RAW-1:2], 2'(k)}] <= s_wdata[k*8 +: 8];
                    else if (s_addr[31:6] == EBASE[31:6]) emem[s_addr[5:2]][k*8 +: 8] <= s_wdata[k*8 +: 8];
                end
            end
        end
    end

    always @(negedge clk) begin
        rdy_cnt = rdy_cnt + 1;
        s_ready = !stall || (rdy_cnt % 3 != 0);
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [31:0] a, input logic [31:0] wd,
                          input logic [3:0] be, output logic [31:0] rd,
                          output int waits, output logic seen_rd, output logic seen_wr,
                          output logic order_ok);
        seen_rd = 1'b0; seen_wr = 1'b0; order_ok = 1'b1; waits = 0;
        m_valid = 1'b1; m_write = wr; m_addr = a; m_wdata = wd; m_be = be;
        #1;
        while (!m_ready) begin
            if (s_lock) begin
                if (s_write) begin
                    seen_wr = 1'b1;
                    if (!seen_rd) order_ok = 1'b0;
                end else begin
                    seen_rd = 1'b1;
                    if (seen_wr) order_ok = 1'b0;
                end
            end
            @(negedge clk); #1;
            waits++;
        end
        rd = m_rdata;
        @(posedge clk);
        @(negedge clk);
        m_valid = 1'b0; m_write = 1'b0;
    endtask

    function automatic logic [31:0] ref_word(input int wi);
        return {rref[wi*4+3], rref[wi*4+2], rref[wi*4+1], rref[wi*4]};
    endfunction

    task automatic alias_bit_test(input int k, input int b, input logic v, input logic chk_time);
        logic [31:0] rd, a;
        int          w;
        logic        sr, sw, ok;
        a = ABASE + 32'(k * 32 + b * 4);
        access(1'b1, a, {31'h5A5A_F0F0 ^ 31'(k * 977 + b), v}, 4'hF, rd, w, sr, sw, ok);
        rref[k][b] = v;
        check("R7 locked read then locked write", {30'd0, sr & sw, ok}, 32'd3);
        if (chk_time) check("R8 ack cycle count", 32'(w), 32'd3);
        else if (w < 3) check("R10 stalled rmw waits", 32'(w), 32'd3);
        access(1'b0, a, '0, 4'hF, rd, w, sr, sw, ok);
        check("R4 alias read bit0 only", rd, {31'd0, rref[k][b]});
        if (chk_time) check("R4 alias read same cycle", 32'(w), 32'd0);
        access(1'b0, RBASE + 32'(k & ~3), '0, 4'hF, rd, w, sr, sw, ok);
        check("R3 R5 R6 direct word after alias write", rd, ref_word(k / 4));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int          w;
        logic        sr, sw, ok;
        for (int i = 0; i < NBYTE; i++) begin
            rmem[i] = 8'(i * 37 + 11);
            rref[i] = 8'(i * 37 + 11);
        end
        for (int i = 0; i < 16; i++) begin
            emem[i] = '0;
            eref[i] = '0;
        end
        repeat (3) @(negedge clk);
        #1;
        check("R9 lock low after reset", {31'd0, s_lock}, 32'd0);
        check("R9 no slave request when idle", {31'd0, s_valid}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check("R9 lock low out of reset", {31'd0, s_lock}, 32'd0);

        // R1: full-width pass-through, then a partial byte-enable write
        for (int i = 0; i < 16; i++) begin
            access(1'b1, EBASE + 32'(i * 4), 32'hC3A5_0000 + 32'(i * 4097), 4'hF, rd, w, sr, sw, ok);
            eref[i] = 32'hC3A5_0000 + 32'(i * 4097);
            check("R1 pass-through write no delay", 32'(w), 32'd0);
        end
        access(1'b1, EBASE + 32'd8, 32'h1122_3344, 4'b0101, rd, w, sr, sw, ok);
        eref[2] = {eref[2][31:24], 8'h22, eref[2][15:8], 8'h44};
        for (int i = 0; i < 16; i++) begin
            access(1'b0, EBASE + 32'(i * 4), '0, 4'hF, rd, w, sr, sw, ok);
            check("R1 pass-through full-width read", rd, eref[i]);
        end

        // R2: direct byte writes to the region
        access(1'b1, RBASE + 32'd4, 32'hAB00_00CD, 4'b1001, rd, w, sr, sw, ok);
        rref[4] = 8'hCD; rref[7] = 8'hAB;
        access(1'b0, RBASE + 32'd4, '0, 4'hF, rd, w, sr, sw, ok);
        check("R2 region byte-enable write", rd, ref_word(1));
        check("R2 region access not locked", 32'(w), 32'd0);

        // exhaustive alias sweep, slave always ready
        for (int k = 0; k < NBYTE; k++) begin
            for (int b = 0; b < 8; b++) begin
                alias_bit_test(k, b, ~rref[k][b], 1'b1);
            end
        end
        for (int k = 0; k < NBYTE; k++) begin
            for (int b = 0; b < 8; b++) begin
                alias_bit_test(k, b, 1'(((k * 5 + b * 3) >> 1) & 1), 1'b1);
            end
        end

        // R10: first, middle and last bytes with slave stalls
        stall = 1'b1;
        for (int j = 0; j < 3; j++) begin
            int k;
            k = (j == 0) ? 0 : (j == 1) ? NBYTE / 2 : NBYTE - 1;
            for (int b = 0; b < 8; b++) begin
                alias_bit_test(k, b, ~rref[k][b], 1'b0);
                alias_bit_test(k, b, ~rref[k][b], 1'b0);
            end
        end
        stall = 1'b0;
        @(negedge clk);

        // R1: first address past the window passes through, region untouched
        access(1'b1, ABASE + 32'(NBYTE * 32), 32'hFFFF_FFFF, 4'hF, rd, w, sr, sw, ok);
        check("R1 past window no rmw", {30'd0, sr, sw}, 32'd0);
        check("R1 past window immediate", 32'(w), 32'd0);
        for (int i = 0; i < NBYTE / 4; i++) begin
            access(1'b0, RBASE + 32'(i * 4), '0, 4'hF, rd, w, sr, sw, ok);
            check("R6 region unchanged by outside write", rd, ref_word(i));
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
        $finish;
    end

endmodule